// File: doc/BRIEF.md
# Chained Converter Serial Read-Out Path

This block is the output shift path of a data converter's serial port. It lets several converters hang on one serial read. Each converter holds its own latest result, an optional channel tag, and a mode pair. One mode bit turns the status pin into a serial input that carries an upstream converter's stream. The other mode bit appends a tag field to every word.

When the active-low frame select falls, the output register takes the local word. The serial output then presents that word most significant bit first, and advances one bit on each serial-clock strobe. In chain mode, the bit arriving on the chain input at each strobe enters the register one full word behind the outgoing bit. That bit therefore leaves the device exactly one word length later. The word length is 16 bits untagged and 24 bits tagged.

In regular mode, the device's own word cycles back into the register, so a long frame repeats it. The serial-clock strobe is a one-cycle pulse in the system clock domain that marks a falling serial-clock edge.

Top module: `chain_out`

## Requirements
- R1: While `csN` is high, and throughout reset, `serialOut` is 0, and strobes on `shiftStb` have no effect.
- R2: In the clock edge where `csN` is first sampled low, the output register loads the local word. From the next cycle on, `serialOut` shows that word's most significant bit, and the first word of every frame is the local word, MSB first.
- R3: With `tagEn` = 0, a word is the 16 bits of `localData`. With `tagEn` = 1, a word is 24 bits: `localData`, then `localTag`, then seven 0 bits.
- R4: While `csN` stays low, the output advances by exactly one bit per `shiftStb` pulse. With no pulse, `serialOut` holds its value.
- R5: With `chainEn` = 1, the `chainIn` value sampled at a strobe appears on `serialOut` exactly one word length (16 or 24 strobes) later.
- R6: With `chainEn` = 0, the words after the first repeat the local word, and `chainIn` has no effect on `serialOut`.
- R7: Raising `csN` and lowering it again starts a new frame that begins with the local word, so toggling between words re-reads the same data.
- R8: Three devices chained output-to-input, with the most upstream one in regular mode, return the downstream, middle and upstream words in that order within one frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| csN | input | 1 | Active-low frame select |
| shiftStb | input | 1 | One-cycle pulse marking a falling serial-clock edge |
| chainEn | input | 1 | 1 = status pin acts as chain data input |
| tagEn | input | 1 | 1 = append tag field to each word |
| chainIn | input | 1 | Serial data from the upstream device |
| localData | input | DATA_W | This device's conversion result |
| localTag | input | 1 | Channel tag of the local result |
| serialOut | output | 1 | Serial data output |

## Verification
The assertions assume that `chainEn` and `tagEn` only change while `csN` is high. They also assume that `localData` is stable at the moment a frame opens. The stimulus follows both rules: mode bits and data are changed only between frames, with the frame select raised. Serial strobes are issued one per cycle, and some are also sent while the frame is closed to show they are ignored. The checker counts strobes within a frame to confirm the first-word repetition, instead of looking back a full word length.

// File: rtl/chain_pkg.sv
package chain_pkg;
  typedef struct packed {
    logic load;   // capture the local word
    logic shift;  // advance one bit
    logic drive;  // output enabled
  } shiftCtrl_t;
endpackage

// File: rtl/chain_ctrl.sv
module chain_ctrl
  import chain_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       shiftStb,
  output shiftCtrl_t ctrl
);
  logic csPrev;
  logic activeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPrev  <= 1'b1;
      activeQ <= 1'b0;
    end else begin
      csPrev <= csN;
      if (csN)         activeQ <= 1'b0;
      else if (csPrev) activeQ <= 1'b1;
    end
  end

  always_comb begin
    ctrl.load  = !csN && csPrev;
    ctrl.shift = !csN && !csPrev && activeQ && shiftStb;
    ctrl.drive = !csN && activeQ;
  end
endmodule

// File: rtl/chain_shift.sv
module chain_shift
  import chain_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  shiftCtrl_t        ctrl,
  input  logic              tagEn,
  input  logic              chainEn,
  input  logic              chainIn,
  input  logic [DATA_W-1:0] localData,
  input  logic              localTag,
  output logic              serialOut
);
  localparam int REG_W = DATA_W + TAG_W;

  logic [REG_W-1:0] shReg;
  logic [REG_W-1:0] loadWord;
  logic [REG_W-1:0] shiftWord;
  logic             feedBit;

  generate
    if (TAG_W > 1) begin : g_padTag
      assign loadWord = tagEn ? {localData, localTag, {(TAG_W-1){1'b0}}}
                              : {localData, {TAG_W{1'b0}}};
    end else begin : g_bareTag
      assign loadWord = tagEn ? {localData, localTag}
                              : {localData, {TAG_W{1'b0}}};
    end
  endgenerate

  assign feedBit = chainEn ? chainIn : shReg[REG_W-1];

  always_comb begin
    shiftWord = {shReg[REG_W-2:0], 1'b0};
    if (tagEn) begin
      shiftWord[0] = feedBit;
    end else begin
      shiftWord[TAG_W-1:0] = '0;
      shiftWord[TAG_W]     = feedBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           shReg <= '0;
    else if (ctrl.load)  shReg <= loadWord;
    else if (ctrl.shift) shReg <= shiftWord;
  end

  assign serialOut = ctrl.drive & shReg[REG_W-1];
endmodule

// File: rtl/chain_out.sv
module chain_out
  import chain_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              shiftStb,
  input  logic              chainEn,
  input  logic              tagEn,
  input  logic              chainIn,
  input  logic [DATA_W-1:0] localData,
  input  logic              localTag,
  output logic              serialOut
);
  shiftCtrl_t ctrl;

  chain_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .shiftStb (shiftStb),
    .ctrl     (ctrl)
  );

  chain_shift #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_shift (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .tagEn     (tagEn),
    .chainEn   (chainEn),
    .chainIn   (chainIn),
    .localData (localData),
    .localTag  (localTag),
    .serialOut (serialOut)
  );
endmodule

// File: rtl/chain_out_chk.sv
module chain_out_chk #(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              shiftStb,
  input logic              chainEn,
  input logic              tagEn,
  input logic [DATA_W-1:0] localData,
  input logic              serialOut
);
  localparam int REG_W = DATA_W + TAG_W;
  localparam int CW    = $clog2(REG_W + 1) + 1;
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
  localparam logic [CW-1:0] ONE_WORD = CW'(DATA_W);

  logic          csPrevC;
  logic          firstBit;
  logic [CW-1:0] stbCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPrevC  <= 1'b1;
      firstBit <= 1'b0;
      stbCnt   <= '0;
    end else begin
      csPrevC <= csN;
      if (!csN && csPrevC) begin
        stbCnt   <= '0;
        firstBit <= localData[DATA_W-1];
      end else if (!csN && shiftStb && stbCnt != CNT_MAX) begin
        stbCnt <= stbCnt + 1'b1;
      end
    end
  end

  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !serialOut);

  assert_first_msb_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && csPrevC) |=> (csN || serialOut == $past(localData[DATA_W-1])));

  assert_hold_no_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !csPrevC && !shiftStb) |=> (csN || $stable(serialOut)));

  assert_repeat_own_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !csPrevC && stbCnt == ONE_WORD && !chainEn && !tagEn)
      |-> serialOut == firstBit);
endmodule

bind chain_out chain_out_chk #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .csN       (csN),
  .shiftStb  (shiftStb),
  .chainEn   (chainEn),
  .tagEn     (tagEn),
  .localData (localData),
  .serialOut (serialOut)
);

// File: tb/sim_chain_out.sv
`timescale 1ns/1ps
module sim_chain_out;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic shiftStb = 1'b0;
  logic tagEn = 1'b0;
  logic chainEnA = 1'b1;
  logic [15:0] dA = '0, dB = '0, dC = '0;
  logic tA = 1'b0, tB = 1'b0, tC = 1'b0;
  logic outA, outB, outC;
  logic [71:0] got;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  // u0: downstream (observed), upB: middle, upC: most upstream (regular mode)
  chain_out u0 (.clk(clk), .rstN(rstN), .csN(csN), .shiftStb(shiftStb),
    .chainEn(chainEnA), .tagEn(tagEn), .chainIn(outB), .localData(dA),
    .localTag(tA), .serialOut(outA));
  chain_out upB (.clk(clk), .rstN(rstN), .csN(csN), .shiftStb(shiftStb),
    .chainEn(1'b1), .tagEn(tagEn), .chainIn(outC), .localData(dB),
    .localTag(tB), .serialOut(outB));
  chain_out upC (.clk(clk), .rstN(rstN), .csN(csN), .shiftStb(shiftStb),
    .chainEn(1'b0), .tagEn(tagEn), .chainIn(1'b1), .localData(dC),
    .localTag(tC), .serialOut(outC));

  function automatic logic [23:0] mkWord(logic [15:0] d, logic t, logic te);
    return te ? {d, t, 7'b0} : {8'b0, d};
  endfunction

  task automatic check(string req, logic [71:0] act, logic [71:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic readBits(int n);
    got = '0;
    @(negedge clk); csN = 1'b0;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      got = {got[70:0], outA};
      shiftStb = 1'b1;
      @(negedge clk);
    end
    shiftStb = 1'b0;
    csN = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [71:0] chunk(int k, int total, int w);
    logic [71:0] mask;
    mask = (72'd1 << w) - 72'd1;
    return (got >> ((total - 1 - k) * w)) & mask;
  endfunction

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset output", {71'b0, outA}, 72'd0);
    rstN = 1'b1;
    @(negedge clk);
    for (int te = 0; te < 2; te++) begin
      for (int s = 0; s < 6; s++) begin
        int w;
        logic [71:0] wa, wb, wc;
        tagEn = te[0];
        dA = 16'hA5C3 ^ 16'(s * 16'h1357);
        dB = 16'h3C96 + 16'(s * 16'h0F0F);
        dC = ~dA ^ 16'(s * 16'h00FF);
        tA = s[0]; tB = ~s[0]; tC = s[1];
        w = te ? 24 : 16;
        wa = 72'(mkWord(dA, tA, te[0]));
        wb = 72'(mkWord(dB, tB, te[0]));
        wc = 72'(mkWord(dC, tC, te[0]));
        // R8 / R5 / R2 / R3: one long frame through the chain
        readBits(3 * w);
        check("R2 R3 first word local", chunk(0, 3, w), wa);
        check("R5 middle word delayed", chunk(1, 3, w), wb);
        check("R8 upstream word last", chunk(2, 3, w), wc);
        // R1: strobes while frame closed, output low
        shiftStb = 1'b1;
        @(negedge clk);
        check("R1 idle low", {71'b0, outA}, 72'd0);
        shiftStb = 1'b0;
        // R7: toggled frames re-read local word
        for (int r = 0; r < 3; r++) begin
          readBits(w);
          check("R7 toggled frame local", chunk(0, 1, w), wa);
        end
        // R6: regular mode repeats, chainIn (active upstream) ignored
        chainEnA = 1'b0;
        readBits(2 * w);
        check("R6 repeat first", chunk(0, 2, w), wa);
        check("R6 repeat second", chunk(1, 2, w), wa);
        chainEnA = 1'b1;
        // R4: no strobe, output holds first bit
        @(negedge clk); csN = 1'b0;
        repeat (5) @(negedge clk);
        check("R4 hold without strobe", {71'b0, outA}, {71'b0, dA[15]});
        csN = 1'b1;
        @(negedge clk);
      end
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule